// File: doc/BRIEF.md
# Interpolating FIR Stage with Rate Strobe and Bypass

This block is one channel of an up-sampling filter in a transmit path where the input and output sides share one clock. A small rate generator produces a one-cycle strobe every `RATE` clocks. The filter takes a new input sample only in a cycle where that strobe and the upstream valid are both high. Each accepted sample is treated as one sample followed by `RATE-1` zeros and passed through a FIR with signed integer coefficients. The `RATE` output phases it produces are computed on successive clocks into an output register.

A run-time `active` input selects what leaves the block. When `active` is low, the upstream valid, enable and data pass straight through. When `active` is high, the output valid is the rate strobe, the output enable follows the upstream enable, and the output data is the filter register. The rate generator is held in its idle state while `active` is low, so every activation starts a fresh strobe pattern.

The rate generator is a two-state machine:
- RG_HOLD moves to RG_RUN when `active` is sampled high.
- RG_RUN moves back to RG_HOLD when `active` is sampled low.

The phase sequencer has states SQ_IDLE and SQ_BURST:
- An accepted sample moves either state to SQ_BURST at phase 0.
- SQ_BURST steps one phase per clock.
- After phase `RATE-1`, SQ_BURST returns to SQ_IDLE unless a new sample is accepted in that same cycle.

Top module: `txi_fir_interp`

## Requirements
- R1: While the rate generator runs, the strobe is high for exactly one cycle, and consecutive strobes are exactly `RATE` (default 4) cycles apart.
- R2: While `active` is sampled low the generator stays in RG_HOLD and gives no strobe. The first strobe comes in the cycle after the first clock edge at which `active` is sampled high.
- R3: An input sample is accepted only in a cycle where both the strobe and `in_valid` are high. Samples offered in any other cycle have no effect on later filter outputs.
- R4: With `active` high, `out_valid` equals the strobe and `out_en` equals `in_en` in the same cycle.
- R5: With `active` low, `out_valid`, `out_en` and `out_data` equal `in_valid`, `in_en` and `in_data` in the same cycle.
- R6: Phase p (0 to `RATE-1`) of a sample accepted in cycle c appears on `out_data` in cycle c+2+p. Its value is the convolution of the coefficients with the zero-stuffed input sequence. The coefficients are 16-bit signed integers, with tap k stored at bits [16k+15:16k] of `COEFS`. Data are 16-bit two's complement.
- R7: The accumulated sum is scaled by 2^-`OUT_SHIFT` (default 4), rounded to nearest with ties going toward zero, and then saturated to the range -32768..32767.
- R8: When no phase burst is running (SQ_IDLE), the filtered `out_data` register holds its value.
- R9: After reset the generator is in RG_HOLD, the sequencer is in SQ_IDLE, and the filter register and sample history are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both data sides |
| rst | input | 1 | Synchronous reset, active high |
| active | input | 1 | 1 selects the filtered stream, 0 selects pass-through |
| in_valid | input | 1 | Upstream sample valid |
| in_en | input | 1 | Upstream channel enable |
| in_data | input | DATA_W | Upstream sample, two's complement |
| out_valid | output | 1 | Strobe when filtering, upstream valid when bypassed |
| out_en | output | 1 | Upstream enable, in both modes |
| out_data | output | DATA_W | Filter register or upstream sample |

## Verification
Several properties are checked on every cycle by assertions:
- the strobe never lasts two cycles;
- a strobe comes only after `active` was high;
- no strobe follows a cycle with `active` low;
- an accepted sample always starts a burst at phase 0;
- the output register is frozen while the sequencer is idle.

Other behaviour can only be shown by the bench scenarios, which compare against a zero-stuff-and-convolve model with its own rounding. These cover:
- the exact `RATE` spacing of strobes;
- the gating of accepted samples;
- the numeric value and timing of each phase;
- saturation at both full-scale extremes;
- exact pass-through in bypass.

// File: rtl/txi_fir_pkg.sv
package txi_fir_pkg;
    typedef enum logic {RG_HOLD, RG_RUN} rg_state_t;
    typedef enum logic {SQ_IDLE, SQ_BURST} sq_state_t;
endpackage

// File: rtl/txi_rate_strobe.sv
module txi_rate_strobe
    import txi_fir_pkg::*;
#(
    parameter int RATE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic strobe
);
    localparam int CW = (RATE > 1) ? $clog2(RATE) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(RATE - 1);

    rg_state_t st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RG_HOLD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            RG_HOLD: begin
                cnt_d = '0;
                if (active) st_d = RG_RUN;
            end
            RG_RUN: begin
                if (!active) begin
                    st_d  = RG_HOLD;
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = RG_HOLD;
        endcase
    end

    always_comb begin
        strobe = (st_q == RG_RUN) && (cnt_q == '0);
    end

    // R1: a strobe is never two cycles long
    p_strobe_single_r1: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
    // R2: a strobe only follows a cycle with active high
    p_strobe_after_active_r2: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(active));
    // R2: active low holds the generator silent on the next cycle
    p_hold_silent_r2: assert property (@(posedge clk) disable iff (rst)
        !active |=> !strobe);
endmodule

// File: rtl/txi_round_sat.sv
module txi_round_sat #(
    parameter int IN_W  = 34,
    parameter int OUT_W = 16,
    parameter int SHIFT = 4
) (
    input  logic signed [IN_W-1:0] acc,
    output logic [OUT_W-1:0]       res
);
    localparam logic signed [IN_W-1:0] HALF    = IN_W'(1) << (SHIFT - 1);
    localparam logic signed [IN_W-1:0] HALF_M1 = HALF - IN_W'(1);
    localparam logic signed [IN_W-1:0] MAXV    = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] MINV    = ~MAXV;

    logic signed [IN_W-1:0] biased;
    logic signed [IN_W-1:0] scaled;

    always_comb begin
        // ties go toward zero: negative values get the full half, positive one less
        biased = acc + (acc[IN_W-1] ? HALF : HALF_M1);
        scaled = biased >>> SHIFT;
        if (scaled > MAXV)      res = MAXV[OUT_W-1:0];
        else if (scaled < MINV) res = MINV[OUT_W-1:0];
        else                    res = scaled[OUT_W-1:0];
    end
endmodule

// File: rtl/txi_poly_mac.sv
module txi_poly_mac
    import txi_fir_pkg::*;
#(
    parameter int DATA_W         = 16,
    parameter int COEF_W         = 16,
    parameter int RATE           = 4,
    parameter int TAPS_PER_PHASE = 2,
    parameter int OUT_SHIFT      = 4,
    parameter logic [RATE*TAPS_PER_PHASE*COEF_W-1:0] COEFS = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] sample,
    output logic [DATA_W-1:0] y_q
);
    localparam int PW = (RATE > 1) ? $clog2(RATE) : 1;
    localparam int AW = DATA_W + COEF_W + $clog2(TAPS_PER_PHASE) + 1;
    localparam logic [PW-1:0] PH_LAST = PW'(RATE - 1);

    logic [DATA_W-1:0] hist_q [TAPS_PER_PHASE];
    sq_state_t sq_q, sq_d;
    logic [PW-1:0] ph_q, ph_d;
    logic signed [AW-1:0] acc;
    logic [DATA_W-1:0] y_d;

    // sample history, newest at index 0
    for (genvar t = 0; t < TAPS_PER_PHASE; t++) begin : g_tap
        if (t == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)       hist_q[t] <= '0;
                else if (take) hist_q[t] <= sample;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)       hist_q[t] <= '0;
                else if (take) hist_q[t] <= hist_q[t-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q <= SQ_IDLE;
            ph_q <= '0;
        end else begin
            sq_q <= sq_d;
            ph_q <= ph_d;
        end
    end

    always_comb begin
        sq_d = sq_q;
        ph_d = ph_q;
        if (take) begin
            sq_d = SQ_BURST;
            ph_d = '0;
        end else begin
            unique case (sq_q)
                SQ_IDLE: ph_d = '0;
                SQ_BURST: begin
                    if (ph_q == PH_LAST) begin
                        sq_d = SQ_IDLE;
                        ph_d = '0;
                    end else begin
                        ph_d = ph_q + 1'b1;
                    end
                end
                default: sq_d = SQ_IDLE;
            endcase
        end
    end

    // polyphase sum: phase p uses taps p, p+RATE, p+2*RATE, ...
    always_comb begin
        logic signed [AW-1:0] xe;
        logic signed [AW-1:0] ce;
        acc = '0;
        for (int j = 0; j < TAPS_PER_PHASE; j++) begin
            xe  = AW'($signed(hist_q[j]));
            ce  = AW'($signed(COEFS[(j*RATE + int'(ph_q))*COEF_W +: COEF_W]));
            acc = acc + xe * ce;
        end
    end

    txi_round_sat #(
        .IN_W (AW),
        .OUT_W(DATA_W),
        .SHIFT(OUT_SHIFT)
    ) u_round (
        .acc(acc),
        .res(y_d)
    );

    always_ff @(posedge clk) begin
        if (rst)                   y_q <= '0;
        else if (sq_q == SQ_BURST) y_q <= y_d;
    end

    // R6: an accepted sample always starts a burst at phase 0
    p_burst_start_r6: assert property (@(posedge clk) disable iff (rst)
        take |=> (sq_q == SQ_BURST) && (ph_q == '0));
    // R6: a finished burst with no new sample goes idle
    p_burst_end_r6: assert property (@(posedge clk) disable iff (rst)
        (sq_q == SQ_BURST && ph_q == PH_LAST && !take) |=> (sq_q == SQ_IDLE));
    // R8: output register frozen while idle
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (sq_q == SQ_IDLE) |=> $stable(y_q));
endmodule

// File: rtl/txi_fir_interp.sv
module txi_fir_interp #(
    parameter int DATA_W         = 16,
    parameter int COEF_W         = 16,
    parameter int RATE           = 4,
    parameter int TAPS_PER_PHASE = 2,
    parameter int OUT_SHIFT      = 4,
    parameter logic [RATE*TAPS_PER_PHASE*COEF_W-1:0] COEFS =
        {16'hFFFE, 16'd5, 16'd12, 16'd20, 16'd20, 16'd12, 16'd5, 16'hFFFE}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              in_valid,
    input  logic              in_en,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_en,
    output logic [DATA_W-1:0] out_data
);
    logic strobe;
    logic take;
    logic [DATA_W-1:0] filt_q;

    txi_rate_strobe #(
        .RATE(RATE)
    ) u_rate (
        .clk   (clk),
        .rst   (rst),
        .active(active),
        .strobe(strobe)
    );

    // R3: a sample enters only on strobe with upstream valid
    assign take = strobe & in_valid;

    txi_poly_mac #(
        .DATA_W        (DATA_W),
        .COEF_W        (COEF_W),
        .RATE          (RATE),
        .TAPS_PER_PHASE(TAPS_PER_PHASE),
        .OUT_SHIFT     (OUT_SHIFT),
        .COEFS         (COEFS)
    ) u_mac (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .sample(in_data),
        .y_q   (filt_q)
    );

    // R4 / R5: output selection
    always_comb begin
        out_en = in_en;
        if (active) begin
            out_valid = strobe;
            out_data  = filt_q;
        end else begin
            out_valid = in_valid;
            out_data  = in_data;
        end
    end
endmodule

// File: tb/txi_fir_interp_test.sv
module txi_fir_interp_test;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 4;
    localparam int K    = 2;
    localparam int TAPS = N * K;
    localparam int SH   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic active = 1'b0, in_valid = 1'b0, in_en = 1'b0;
    logic [15:0] in_data = '0;
    logic out_valid, out_en;
    logic [15:0] out_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    txi_fir_interp uut (
        .clk(clk), .rst(rst), .active(active), .in_valid(in_valid),
        .in_en(in_en), .in_data(in_data), .out_valid(out_valid),
        .out_en(out_en), .out_data(out_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit     m_run = 0;
    int     m_cnt = 0;
    bit     m_busy = 0;
    int     m_ph = 0;
    longint m_out = 0;
    longint cur [N];
    longint up [TAPS];
    int     cyc = 0;
    int     last_pulse = -1;
    string  dtag = "R6";

    function automatic longint coef(int k);
        case (k)
            0, 7:    return -2;
            1, 6:    return 5;
            2, 5:    return 12;
            default: return 20;
        endcase
    endfunction

    // R7: scale, round half toward zero, saturate
    function automatic longint rnd_sat(longint a);
        longint half = longint'(1) << (SH - 1);
        longint q;
        if (a >= 0) q = (a + half - 1) >>> SH;
        else        q = -(((-a) + half - 1) >>> SH);
        if (q > 32767)  q = 32767;
        if (q < -32768) q = -32768;
        return q;
    endfunction

    task automatic check(string tag, string what, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d actual %0d expected %0d", tag, what, cyc, got, exp);
        end
    endtask

    // zero-stuff the sample into the upsampled buffer and convolve each phase
    task automatic push_sample(longint x);
        for (int p = 0; p < N; p++) begin
            longint s = 0;
            for (int k = TAPS - 1; k > 0; k--) up[k] = up[k-1];
            up[0] = (p == 0) ? x : 0;
            for (int k = 0; k < TAPS; k++) s += coef(k) * up[k];
            cur[p] = rnd_sat(s);
        end
    endtask

    function automatic bit pulse_now();
        return m_run && (m_cnt == 0);
    endfunction

    task automatic step(bit a, bit v, bit e, logic [15:0] d);
        bit pulse, take;
        string vtag;
        @(negedge clk);
        active = a; in_valid = v; in_en = e; in_data = d;
        #1;
        pulse = pulse_now();
        vtag = (!m_run || last_pulse < 0) ? "R2" : "R1";
        if (a) begin
            check(vtag, "strobe", longint'(out_valid), longint'(pulse));
            check("R4", "enable", longint'(out_en), longint'(e));
            check(dtag, "data", longint'($signed(out_data)), m_out);
            if (pulse) begin
                if (last_pulse >= 0) check("R1", "strobe gap", cyc - last_pulse, N);
                last_pulse = cyc;
            end
        end else begin
            check("R5", "bypass valid", longint'(out_valid), longint'(v));
            check("R5", "bypass enable", longint'(out_en), longint'(e));
            check("R5", "bypass data", longint'(out_data), longint'(d));
        end
        // effects of the coming clock edge
        take = pulse && v;   // R3
        if (m_busy) m_out = cur[m_ph];
        if (take) begin
            m_busy = 1; m_ph = 0;
            push_sample(longint'($signed(d)));
        end else if (m_busy) begin
            if (m_ph == N - 1) begin m_busy = 0; m_ph = 0; end
            else m_ph++;
        end
        if (!a) begin m_run = 0; m_cnt = 0; last_pulse = -1; end
        else if (!m_run) begin m_run = 1; m_cnt = 0; end
        else m_cnt = (m_cnt + 1) % N;
        cyc++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int taken;
        void'($urandom(32'd20417));
        for (int k = 0; k < TAPS; k++) up[k] = 0;
        for (int p = 0; p < N; p++) cur[p] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state seen through the filtered path
        @(negedge clk);
        active = 1'b1; in_valid = 1'b1; in_en = 1'b0; in_data = 16'h1234;
        #1;
        check("R9", "reset data", longint'(out_data), 0);
        check("R9", "reset strobe", longint'(out_valid), 0);
        active = 1'b0;

        // R5: bypass with varied inputs
        for (int i = 0; i < 20; i++)
            step(0, 1'($urandom), 1'($urandom), 16'($urandom));

        // R6: impulse response, then zeros
        dtag = "R6";
        taken = 0;
        for (int i = 0; i < 24; i++) begin
            bit pn = pulse_now();
            step(1, 1, 1, (taken == 0) ? 16'd16384 : 16'd0);
            if (pn) taken++;
        end

        // R7: full-scale positive then negative saturates
        dtag = "R7";
        for (int i = 0; i < 16; i++) step(1, 1, 1, 16'h7FFF);
        for (int i = 0; i < 16; i++) step(1, 1, 0, 16'h8000);
        for (int i = 0; i < 16; i++) step(1, 1, 1, 16'h0013);

        // R8: no valid input, register must hold
        dtag = "R8";
        for (int i = 0; i < 20; i++) step(1, 0, 1, 16'($urandom));

        // R3: valid offered only off-strobe must not enter the filter
        dtag = "R3";
        for (int i = 0; i < 24; i++) begin
            bit pn = pulse_now();
            step(1, !pn, 1, 16'($urandom));
        end

        // random mix with occasional bypass stretches
        dtag = "R6";
        for (int i = 0; i < 3000; i++) begin
            bit a = (($urandom % 100) >= 8);
            step(a, (($urandom % 100) < 75), 1'($urandom), 16'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule